// File: doc/BRIEF.md
# Serial Read-Back Port with Data-Ready Request

This block is the slave end of an SPI-style control link through which a host pulls queued bytes out of a chip. On the chip side, bytes arrive on a valid/ready stream, and each one carries a flag that marks the final byte of a message. On the host side there are a chip select, a serial clock that idles low, a data input, a data output, and an active-low request line. The request line drops when a message is waiting. It rises again partway through the final byte, so the host knows to stop once that byte is complete.

Every transaction begins with a command byte. If its least significant bit is 1, the transaction is a read. In that case the block presents the first data bit after the falling clock edge that ends the command byte. It then streams the message most significant bit first, changing the output only after falling edges. If chip select rises before the final byte has been sent, the rest of that message is drained from the stream and discarded.

All host pins are brought into the system clock domain through two-flop synchronisers. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_read_port`

## Requirements
- R1: After reset the request line is high, data-out is 0 and the stream ready output is 0.
- R2: While chip select is high and the stream offers a byte, the request line goes low within a few system clocks.
- R3: The command byte is captured most significant bit first on rising serial clock edges. Only its bit 0 decides the direction, and 1 means read. With bit 0 equal to 0, nothing is taken from the stream, data-out stays 0 and the request line keeps its level.
- R4: In a read, data bits appear most significant bit first. The first bit is valid after the falling edge of the eighth command clock. Data-out holds steady through every high phase of the serial clock.
- R5: The request line stays low until the seventh rising edge of the byte that carries the last flag. It is high after that edge and stays high until chip select rises.
- R6: Several bytes of one message are sent back to back in a single chip-select cycle, each stream byte exactly once and in stream order. A message that ends frees the port, and a second message is only sent in a later transaction.
- R7: When chip select rises before the final byte of a message has been sent, the bit count resets and the unread remainder of that message, up to and including its last-flag byte, is discarded. The next read starts with the following message.
- R8: Data-out is 0 while chip select is high. It is also 0 during a read when no byte was available to load, and in that case the request line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| reqN | output | 1 | Active-low request: data waiting / final byte under way |
| inData | input | BYTE_W | Stream byte to send |
| inValid | input | 1 | Stream byte present |
| inLast | input | 1 | Stream byte is the last of its message |
| inReady | output | 1 | Stream byte taken this clock |

## Verification
The bench goes after the end-of-message timing first. It reads the request line late in the high phase of the sixth and seventh clocks of every byte. A design that raised it one edge early or one edge late would report the wrong byte as final. A write command is sent while data is pending: a port that ignored the direction bit would pop a byte or drive data-out. A transfer is cut off three bits into the second byte of a four-byte message, and a port that did not flush would return stale bytes on the next read. A read with an empty queue has to clock out zeros and keep the request high.

// File: rtl/spi_read_pkg.sv
package spi_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_SKIP,
    ST_FLUSH
  } portState_t;

  // strobes from control to datapath, at most one tx action per clock
  typedef struct packed {
    logic cmdShift;
    logic txLoad;
    logic txShift;
    logic txClear;
  } dpStrobe_t;

endpackage

// File: rtl/spi_read_sync.sv
module spi_read_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive,
  output logic csStart,
  output logic csEnd,
  output logic mosiS
);

  localparam int LANES = 3;
  // reset level of each lane: sclk low, csN high, mosi low
  localparam logic [LANES-1:0] IDLE_LVL = 3'b010;

  logic [LANES-1:0] rawIn;
  logic [LANES-1:0] synced;
  logic sclkPrev;
  logic csPrev;

  assign rawIn = {mosi, csN, sclk};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE_LVL[g]}};
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= synced[0];
      csPrev   <= synced[1];
    end
  end

  assign sclkRise = synced[0] & ~sclkPrev;
  assign sclkFall = ~synced[0] & sclkPrev;
  assign csActive = ~synced[1];
  assign csStart  = ~synced[1] & csPrev;
  assign csEnd    = synced[1] & ~csPrev;
  assign mosiS    = synced[2];

endmodule

// File: rtl/spi_read_dp.sv
module spi_read_dp
  import spi_read_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  input  logic              sclkFall,
  input  logic              csEnd,
  input  logic              csActive,
  input  logic              mosiS,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              cmdRead,
  output logic              loaded,
  output logic              byteLast,
  output logic              miso
);

  logic [BYTE_W-1:0] cmdReg;
  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (ctl.cmdShift) cmdReg <= {cmdReg[BYTE_W-2:0], mosiS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      loaded   <= 1'b0;
      byteLast <= 1'b0;
    end else if (ctl.txClear) begin
      txReg    <= '0;
      loaded   <= 1'b0;
      byteLast <= 1'b0;
    end else if (ctl.txLoad) begin
      txReg    <= inData;
      loaded   <= 1'b1;
      byteLast <= inLast;
    end else if (ctl.txShift) begin
      txReg    <= {txReg[BYTE_W-2:0], 1'b0};
    end
  end

  assign cmdRead = cmdReg[0];
  assign miso    = csActive & loaded & txReg[BYTE_W-1];

  // R4: the outgoing bit may only move on a falling serial edge
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txShift || ctl.txLoad) |-> sclkFall);

  // R8: ending chip select empties the shifter
  a_r8_clear_on_end: assert property (@(posedge clk) disable iff (!rstN)
    csEnd |=> !loaded);

endmodule

// File: rtl/spi_read_ctrl.sv
module spi_read_ctrl
  import spi_read_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkRise,
  input  logic      sclkFall,
  input  logic      csStart,
  input  logic      csEnd,
  input  logic      cmdRead,
  input  logic      loaded,
  input  logic      byteLast,
  input  logic      inValid,
  input  logic      inLast,
  output dpStrobe_t ctl,
  output logic      inReady,
  output logic      reqN
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] PENULT = CNT_W'(BYTE_W - 2);

  portState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             endSent;
  logic             lastPopped;
  logic             poppedAny;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_CMD: begin
        if (sclkRise && bitCnt < FULL) ctl.cmdShift = 1'b1;
        if (sclkFall && bitCnt == FULL && cmdRead) begin
          if (inValid) ctl.txLoad  = 1'b1;
          else         ctl.txClear = 1'b1;
        end
      end
      ST_READ: begin
        if (sclkFall) begin
          if (bitCnt == FULL) begin
            if (!endSent && !lastPopped && inValid) ctl.txLoad  = 1'b1;
            else                                    ctl.txClear = 1'b1;
          end else if (bitCnt != '0) begin
            ctl.txShift = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (csEnd) begin
      ctl         = '0;
      ctl.txClear = 1'b1;
    end
  end

  assign inReady = ctl.txLoad || (state == ST_FLUSH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      endSent    <= 1'b0;
      lastPopped <= 1'b0;
      poppedAny  <= 1'b0;
      reqN       <= 1'b1;
    end else if (csEnd) begin
      state  <= (state == ST_READ && poppedAny && !lastPopped) ? ST_FLUSH : ST_IDLE;
      bitCnt <= '0;
      reqN   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          reqN <= !inValid;
          if (csStart) begin
            state      <= ST_CMD;
            bitCnt     <= '0;
            endSent    <= 1'b0;
            lastPopped <= 1'b0;
            poppedAny  <= 1'b0;
          end
        end
        ST_CMD: begin
          if (sclkRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (sclkFall && bitCnt == FULL) begin
            bitCnt <= '0;
            if (cmdRead) begin
              state <= ST_READ;
              if (ctl.txLoad) begin
                poppedAny  <= 1'b1;
                lastPopped <= inLast;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_READ: begin
          if (sclkRise && bitCnt < FULL) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == PENULT && (!loaded || byteLast)) begin
              endSent <= 1'b1;
              reqN    <= 1'b1;
            end
          end
          if (sclkFall && bitCnt == FULL) begin
            bitCnt <= '0;
            if (ctl.txLoad) begin
              poppedAny  <= 1'b1;
              lastPopped <= inLast;
            end
          end
        end
        ST_FLUSH: begin
          if (inValid && inLast) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R5: once the final byte is flagged the request stays high
  a_r5_req_high_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && endSent) |-> reqN);

  // R5: inside a read a low request only moves on a serial rise or a deselect
  a_r5_req_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && !reqN && !sclkRise && !csEnd) |=> !reqN);

  // R6: the bit counter never passes one byte
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);

  // R6: nothing is popped once the last-flag byte is in the shifter
  a_r6_no_pop_past_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && lastPopped) |-> !inReady);

  // R7: discarding never announces data
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |-> reqN);

endmodule

// File: rtl/spi_read_port.sv
module spi_read_port
  import spi_read_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              reqN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady
);

  logic      sclkRise, sclkFall, csActive, csStart, csEnd, mosiS;
  logic      cmdRead, loaded, byteLast;
  dpStrobe_t ctl;

  spi_read_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive),
    .csStart(csStart), .csEnd(csEnd), .mosiS(mosiS)
  );

  spi_read_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csStart(csStart), .csEnd(csEnd), .cmdRead(cmdRead), .loaded(loaded),
    .byteLast(byteLast), .inValid(inValid), .inLast(inLast),
    .ctl(ctl), .inReady(inReady), .reqN(reqN)
  );

  spi_read_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sclkFall(sclkFall), .csEnd(csEnd),
    .csActive(csActive), .mosiS(mosiS), .inData(inData), .inLast(inLast),
    .cmdRead(cmdRead), .loaded(loaded), .byteLast(byteLast), .miso(miso)
  );

endmodule

// File: tb/tb_spi_read_port.sv
`timescale 1ns/1ps
module tb_spi_read_port;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso, reqN, inReady;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] srcData[$];
  bit         srcLast[$];
  logic [7:0] expData[$];
  bit         expLast[$];

  logic [7:0] rxData;
  bit         rxLast, rxReqBefore;
  event       rxEv;

  always #4 clk = ~clk;

  spi_read_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .reqN(reqN), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stream source: pop on handshake, present the queue head at negedge
  always @(posedge clk)
    if (rstN && inValid && inReady && srcData.size() > 0) begin
      void'(srcData.pop_front());
      void'(srcLast.pop_front());
    end

  always @(negedge clk) begin
    if (srcData.size() > 0) begin
      inValid <= 1'b1;
      inData  <= srcData[0];
      inLast  <= srcLast[0];
    end else begin
      inValid <= 1'b0;
      inData  <= 8'h00;
      inLast  <= 1'b0;
    end
  end

  // driver: message into source and scoreboard
  task automatic pushMsg(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3, input int n);
    logic [7:0] v[4];
    v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3;
    for (int i = 0; i < n; i++) begin
      srcData.push_back(v[i]);  srcLast.push_back(i == n - 1);
      expData.push_back(v[i]);  expLast.push_back(i == n - 1);
    end
  endtask

  task automatic dropExpected();
    bit l;
    l = 0;
    while (!l && expData.size() > 0) begin
      void'(expData.pop_front());
      l = expLast.pop_front();
    end
  endtask

  // monitor: compare each received byte with the scoreboard head
  always @(rxEv) begin
    logic [7:0] e;
    bit el;
    if (expData.size() == 0) begin
      check(0, "R6", "unexpected byte", rxData, 0);
    end else begin
      e  = expData.pop_front();
      el = expLast.pop_front();
      check(rxData == e, "R6", "byte value", rxData, e);
      check(rxLast == el, "R5", "request at 7th rise", rxLast, el);
      check(rxReqBefore == 0, "R5", "request at 6th rise", rxReqBefore, 0);
    end
  end

  task automatic pulse(input logic mIn, output logic mOut, output bit stable,
                       output logic reqHigh);
    mosi = mIn;
    repeat (HALF) @(negedge clk);
    mOut = miso;
    sclk = 1'b1;
    stable = 1;
    reqHigh = reqN;
    for (int k = 0; k < HALF - 1; k++) begin
      @(negedge clk);
      if (miso !== mOut) stable = 0;
      if (k == HALF - 3) reqHigh = reqN;
    end
    @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    logic m, r;
    bit s;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) pulse(c[i], m, s, r);
  endtask

  task automatic readByte(output logic [7:0] b, output bit lastSeen,
                          output bit reqBefore, output bit stableAll);
    logic m, r;
    bit s;
    stableAll = 1;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, m, s, r);
      b[7 - i] = m;
      if (!s) stableAll = 0;
      if (i == 5) reqBefore = r;
      if (i == 6) lastSeen = r;
    end
  endtask

  task automatic endCs();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic readMsg(input logic [7:0] cmd);
    logic [7:0] b;
    bit l, rb, st;
    sendCmd(cmd);
    for (int n = 0; n < 8; n++) begin
      readByte(b, l, rb, st);
      check(st, "R4", "miso steady in high phase", st, 1);
      rxData = b; rxLast = l; rxReqBefore = rb;
      ->rxEv;
      @(negedge clk);
      if (l) break;
    end
    endCs();
  endtask

  initial begin
    logic [7:0] b;
    bit l, rb, st;
    logic m, r;
    bit s;
    int ones;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqN == 1'b1, "R1", "reqN in reset", reqN, 1);
    check(miso == 1'b0, "R1", "miso in reset", miso, 0);
    check(inReady == 1'b0, "R1", "inReady in reset", inReady, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(reqN == 1'b1, "R1", "reqN idle empty", reqN, 1);

    // R2 / R4 / R5 / R6: three-byte message
    pushMsg(8'hA5, 8'h3C, 8'h0F, 8'h00, 3);
    repeat (6) @(negedge clk);
    check(reqN == 1'b0, "R2", "reqN with data", reqN, 0);
    check(miso == 1'b0, "R8", "miso with cs high", miso, 0);
    readMsg(8'h01);
    check(reqN == 1'b1, "R5", "reqN after drained", reqN, 1);

    // R6: two single-byte messages need two transactions; R3 upper bits ignored
    pushMsg(8'h81, 8'h00, 8'h00, 8'h00, 1);
    pushMsg(8'h7E, 8'h00, 8'h00, 8'h00, 1);
    repeat (6) @(negedge clk);
    readMsg(8'hA3);
    check(reqN == 1'b0, "R6", "second message pending", reqN, 0);
    check(srcData.size() == 1, "R6", "second message untouched", srcData.size(), 1);
    readMsg(8'h01);

    // R3: write command leaves the queue alone
    pushMsg(8'h5A, 8'hB4, 8'h00, 8'h00, 2);
    repeat (6) @(negedge clk);
    sendCmd(8'h42);
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      pulse(i[0], m, s, r);
      if (m !== 1'b0) ones++;
      if (r !== 1'b0) ones++;
    end
    check(ones == 0, "R3", "write: miso zero, reqN low", ones, 0);
    endCs();
    check(srcData.size() == 2, "R3", "write popped nothing", srcData.size(), 2);
    check(reqN == 1'b0, "R3", "reqN kept after write", reqN, 0);
    readMsg(8'h01);

    // R7: abort three bits into byte two
    pushMsg(8'h11, 8'h22, 8'h33, 8'h44, 4);
    pushMsg(8'h99, 8'h00, 8'h00, 8'h00, 1);
    repeat (6) @(negedge clk);
    sendCmd(8'h01);
    readByte(b, l, rb, st);
    rxData = b; rxLast = l; rxReqBefore = rb;
    ->rxEv;
    @(negedge clk);
    for (int i = 0; i < 3; i++) pulse(1'b0, m, s, r);
    endCs();
    dropExpected();
    repeat (20) @(negedge clk);
    check(srcData.size() == 1, "R7", "remainder flushed", srcData.size(), 1);
    check(reqN == 1'b0, "R7", "next message announced", reqN, 0);
    readMsg(8'h01);

    // R8: read with nothing queued
    repeat (6) @(negedge clk);
    check(reqN == 1'b1, "R8", "reqN empty", reqN, 1);
    sendCmd(8'h01);
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, m, s, r);
      if (m !== 1'b0) ones++;
      if (r !== 1'b1) ones++;
    end
    check(ones == 0, "R8", "empty read zeros, reqN high", ones, 0);
    endCs();
    check(expData.size() == 0, "R6", "scoreboard drained", expData.size(), 0);
    check(miso == 1'b0, "R8", "miso after deselect", miso, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule